// File: doc/BRIEF.md
# Interrupt Request Capture Stage

This block is the front end of an eight-input interrupt controller. It brings each raw interrupt line into the clock domain and records pending requests in a request vector. A per-line trigger-mode register decides how each line is captured. In edge mode a rising transition latches a request that stays until it is acknowledged. In level mode the request follows the line while the line is high and drops when the line falls.

Downstream priority logic picks a line and reports it through the acknowledge inputs. The block then updates its own state. It clears the request of an edge-mode line and either marks the line in service or, when automatic end-of-interrupt is on, leaves the in-service vector alone and can move the lowest-priority pointer to that line. A strap parameter selects the primary or the secondary role of the instance. The role fixes which lines are never allowed to use level mode.

Top module: `irq_request_latch`

## Requirements
- R1: After reset the request vector and the in-service vector are all zero, the trigger-mode register is all zero (every line edge mode), and the lowest-priority pointer is 7.
- R2: With the primary strap (IS_SLAVE=0), a mode write stores the written byte ANDed with 8'hF8, so lines 0, 1 and 2 always read back 0 (edge).
- R3: With the secondary strap (IS_SLAVE=1), a mode write stores the written byte ANDed with 8'hDE, so lines 0 and 5 always read back 0 (edge).
- R4: Trigger-mode bit value 0 means edge mode. A rising transition on an edge-mode line sets its request bit on the third rising clock edge after the line changes. This counts two synchroniser stages and the request register.
- R5: A falling transition on an edge-mode line leaves its request bit set.
- R6: Trigger-mode bit value 1 means level mode. While a level-mode line is high its request bit is set, and an acknowledge of that line does not clear it.
- R7: A falling transition on a level-mode line clears its request bit on the third rising clock edge after the line changes.
- R8: An acknowledge (ack_valid with ack_pin) of an edge-mode line clears its request bit on the next clock edge. When auto_eoi is 0 the acknowledge also sets that line's in-service bit.
- R9: An acknowledge with auto_eoi set leaves the in-service vector unchanged. If rotate_en is also set, the lowest-priority pointer takes the acknowledged line number. Otherwise the pointer keeps its value.
- R10: If a new rising transition on an edge-mode line is detected in the same cycle as an acknowledge of that line, the request bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Raw asynchronous interrupt lines |
| mode_wr | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata | input | 8 | Byte written to the trigger-mode register |
| ack_valid | input | 1 | Acknowledge strobe from the priority logic |
| ack_pin | input | 3 | Line number being acknowledged |
| auto_eoi | input | 1 | Automatic end-of-interrupt enable |
| rotate_en | input | 1 | Priority rotation enable |
| trig_mode | output | 8 | Trigger-mode register (1 level, 0 edge) |
| req_bits | output | 8 | Pending request vector |
| svc_bits | output | 8 | In-service vector |
| low_prio | output | 3 | Lowest-priority line pointer |

## Verification
The hardest case to reach is the collision in R10. Here a freshly synchronised rising edge and an acknowledge of the same line land in one cycle. The line must already hold a request from an earlier pulse and then be low. The bench raises it again and asserts the acknowledge on the falling clock edge just after the second synchroniser stage picks up the new level, so both events arrive at the request register on the same rising edge. The level-mode acknowledge case is reached in a similar way. The line is held high across the acknowledge, and the bench then confirms that the request survives while the in-service bit is set.

// File: rtl/irq_request_latch.sv
module irq_request_latch #(
  parameter int LINES = 8,
  parameter bit IS_SLAVE = 1'b0,
  parameter logic [LINES-1:0] PRI_LEVEL_OK = 8'hF8,
  parameter logic [LINES-1:0] SEC_LEVEL_OK = 8'hDE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         irq_in,
  input  logic                     mode_wr,
  input  logic [LINES-1:0]         mode_wdata,
  input  logic                     ack_valid,
  input  logic [$clog2(LINES)-1:0] ack_pin,
  input  logic                     auto_eoi,
  input  logic                     rotate_en,
  output logic [LINES-1:0]         trig_mode,
  output logic [LINES-1:0]         req_bits,
  output logic [LINES-1:0]         svc_bits,
  output logic [$clog2(LINES)-1:0] low_prio
);
  localparam int PW = $clog2(LINES);
  localparam logic [LINES-1:0] LEVEL_OK = IS_SLAVE ? SEC_LEVEL_OK : PRI_LEVEL_OK;

  logic [LINES-1:0] sync_a, sync_b, line_prev;
  logic [LINES-1:0] rise, fall, ack_hot, req_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a    <= '0;
      sync_b    <= '0;
      line_prev <= '0;
    end else begin
      sync_a    <= irq_in;
      sync_b    <= sync_a;
      line_prev <= sync_b;
    end

  assign rise    = sync_b & ~line_prev;
  assign fall    = ~sync_b & line_prev;
  assign ack_hot = ack_valid ? (LINES'(1) << ack_pin) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trig_mode <= '0;
    else if (mode_wr) trig_mode <= mode_wdata & LEVEL_OK;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic set_i, clr_i;
    assign set_i = rise[i] | (trig_mode[i] & sync_b[i]);
    assign clr_i = (trig_mode[i] & fall[i]) | (~trig_mode[i] & ack_hot[i]);
    assign req_nxt[i] = set_i | (req_bits[i] & ~clr_i);

    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_mode[i] && req_bits[i] && !ack_hot[i]) |=> req_bits[i]);
    assert_level_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode[i] && sync_b[i]) |=> req_bits[i]);
    assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && ack_hot[i]) |=> req_bits[i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_bits <= '0;
    else req_bits <= req_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      svc_bits <= '0;
      low_prio <= PW'(LINES - 1);
    end else if (ack_valid) begin
      if (!auto_eoi) svc_bits[ack_pin] <= 1'b1;
      else if (rotate_en) low_prio <= ack_pin;
    end

  assert_mode_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode & ~LEVEL_OK) == '0);
  assert_edge_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !trig_mode[ack_pin] && !rise[ack_pin]) |=> !req_bits[$past(ack_pin)]);
  assert_svc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !auto_eoi) |=> svc_bits[$past(ack_pin)]);
  assert_aeoi_svc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && auto_eoi) |=> $stable(svc_bits));
  assert_rotate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && auto_eoi && rotate_en) |=> low_prio == $past(ack_pin));
endmodule

// File: tb/tb_irq_request_latch.sv
module tb_irq_request_latch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0, mode_wdata = '0;
  logic mode_wr = 1'b0, ack_valid = 1'b0, auto_eoi = 1'b0, rotate_en = 1'b0;
  logic [2:0] ack_pin = '0;
  logic [7:0] trig_mode, req_bits, svc_bits, trig_mode_s, req_s, svc_s;
  logic [2:0] low_prio, low_prio_s;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_request_latch #(.IS_SLAVE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .ack_valid(ack_valid), .ack_pin(ack_pin), .auto_eoi(auto_eoi), .rotate_en(rotate_en),
    .trig_mode(trig_mode), .req_bits(req_bits), .svc_bits(svc_bits), .low_prio(low_prio));

  irq_request_latch #(.IS_SLAVE(1'b1)) dut_sec (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .ack_valid(ack_valid), .ack_pin(ack_pin), .auto_eoi(auto_eoi), .rotate_en(rotate_en),
    .trig_mode(trig_mode_s), .req_bits(req_s), .svc_bits(svc_s), .low_prio(low_prio_s));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    irq_in = '0; mode_wr = 0; ack_valid = 0; auto_eoi = 0; rotate_en = 0;
    rst_n = 0;
    tick(2);
    rst_n = 1;
    tick(1);
  endtask

  task automatic write_mode(input logic [7:0] v);
    mode_wdata = v; mode_wr = 1; tick(1); mode_wr = 0;
  endtask

  task automatic ack(input logic [2:0] p, input logic ae, input logic rot);
    ack_pin = p; auto_eoi = ae; rotate_en = rot; ack_valid = 1;
    tick(1);
    ack_valid = 0; auto_eoi = 0; rotate_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 req", req_bits, 8'h00);
    check("R1 svc", svc_bits, 8'h00);
    check("R1 mode", trig_mode, 8'h00);
    check("R1 lowprio", {5'd0, low_prio}, 8'd7);
  endtask

  task automatic t_mode_masks();
    do_reset();
    write_mode(8'hFF);
    check("R2 primary mask", trig_mode, 8'hF8);
    check("R3 secondary mask", trig_mode_s, 8'hDE);
    write_mode(8'h27);
    check("R2 primary mask 27", trig_mode, 8'h20);
    check("R3 secondary mask 27", trig_mode_s, 8'h06);
  endtask

  task automatic t_edge();
    do_reset();
    irq_in[4] = 1; tick(2);
    check("R4 not yet", req_bits, 8'h00);
    tick(1);
    check("R4 edge set", req_bits, 8'h10);
    irq_in[4] = 0; tick(4);
    check("R5 fall keeps", req_bits, 8'h10);
    ack(3'd4, 0, 0);
    check("R8 ack clears", req_bits, 8'h00);
    check("R8 svc set", svc_bits, 8'h10);
  endtask

  task automatic t_level();
    do_reset();
    write_mode(8'h08);
    irq_in[3] = 1; tick(3);
    check("R6 level set", req_bits, 8'h08);
    ack(3'd3, 0, 0);
    check("R6 ack keeps level", req_bits, 8'h08);
    check("R8 level svc", svc_bits, 8'h08);
    irq_in[3] = 0; tick(2);
    check("R7 not yet", req_bits, 8'h08);
    tick(1);
    check("R7 fall clears", req_bits, 8'h00);
  endtask

  task automatic t_aeoi();
    do_reset();
    irq_in = 8'h30; tick(3);
    check("R4 two lines", req_bits, 8'h30);
    ack(3'd5, 1, 1);
    check("R9 rotate pointer", {5'd0, low_prio}, 8'd5);
    check("R9 no svc", svc_bits, 8'h00);
    check("R9 edge cleared", req_bits, 8'h10);
    ack(3'd4, 1, 0);
    check("R9 pointer held", {5'd0, low_prio}, 8'd5);
    check("R9 no svc 2", svc_bits, 8'h00);
    check("R9 edge cleared 2", req_bits, 8'h00);
  endtask

  task automatic t_collision();
    do_reset();
    irq_in[6] = 1; tick(3);
    irq_in[6] = 0; tick(4);
    check("R10 pending", req_bits, 8'h40);
    irq_in[6] = 1; tick(2);
    ack(3'd6, 0, 0);
    check("R10 edge wins", req_bits, 8'h40);
    check("R10 svc", svc_bits, 8'h40);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_mode_masks();
        t_edge();
        t_level();
        t_aeoi();
        t_collision();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule